// File: doc/BRIEF.md
# Double-Buffered DAC Register Front End

This block is the digital front end of an 8-bit multiplying converter. A byte from a data bus passes through two storage stages in series: an input stage, written under a qualified write strobe, and a converter stage, updated under a separate transfer strobe. The converter stage holds the code that sets the analog ladder. The block brings this code out together with its bitwise complement. These two buses stand in for the pair of complementary current outputs.

Each stage is modelled as a level-sensitive latch. Its register samples on every rising clock edge while its enable is true. When both enables are true in the same cycle, the converter stage takes the value the input stage is loading in that cycle. The pair therefore behaves like two transparent latches in cascade. The control strobes select the mode of use. Double-buffered use writes the input stage first and then transfers. Single-buffered use holds the transfer path open and strobes the first write. Flow-through use holds every strobe active, so the bus reaches the output after one edge.

Top module: `dbuf_dac_front`

## Requirements
- R1: While reset is asserted and after its release, both stages hold zero, so `dacCode` is 0x00 and `dacCodeInv` is 0xFF.
- R2: The input stage loads `dataIn` on a rising edge only when `chipSelN` is 0, `wrOneN` is 0 and `latchEn` is 1. If `chipSelN` is 1 or `wrOneN` is 1, the stage keeps its value.
- R3: The converter stage loads on a rising edge only when `wrTwoN` and `xferN` are both 0. If either of them is 1, `dacCode` keeps its value.
- R4: With `chipSelN`, `wrOneN`, `wrTwoN` and `xferN` at 0 and `latchEn` at 1, `dacCode` equals the `dataIn` value present at the preceding rising edge.
- R5: While `latchEn` is 0, the input stage keeps its value regardless of `chipSelN` and `wrOneN`.
- R6: `dacCodeInv` is always the bitwise complement of `dacCode`, so the two sum to 255. Bit 0 is the LSB and bit 7 is the MSB.
- R7: Writing the input stage while the transfer path is closed leaves `dacCode` unchanged. A later transfer then presents the stored byte.
- R8: With `wrTwoN` and `xferN` held at 0 and `latchEn` at 1, pulsing `wrOneN` low with `chipSelN` at 0 updates `dacCode` in one step. Once `wrOneN` returns to 1, `dacCode` holds that value while `dataIn` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSelN | input | 1 | Chip select, active low |
| latchEn | input | 1 | Input stage qualifier, active high |
| wrOneN | input | 1 | Input stage write strobe, active low |
| wrTwoN | input | 1 | Converter stage write strobe, active low |
| xferN | input | 1 | Transfer qualifier, active low |
| dataIn | input | 8 | Data bus, bit 0 is the LSB |
| dacCode | output | 8 | Code held in the converter stage |
| dacCodeInv | output | 8 | Bitwise complement of `dacCode` |

## Verification
The input stage has no output of its own. Its content can only be seen by transferring it afterwards. The hardest cases to reach are therefore writes that must be ignored: a write with chip select high, and a write with the latch enable low while the other strobes are active. The stimulus follows each such attempt with a transfer-only cycle and expects the byte stored before the attempt. The simultaneous-enable case is reached through flow-through cycles. There, the output must show the bus value from the same edge, not the stale content of the input stage.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  typedef struct packed {
    logic loadIn;
    logic loadDac;
  } stageStrobes_t;
endpackage

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          chipSelN,
  input  logic          latchEn,
  input  logic          wrOneN,
  input  logic          wrTwoN,
  input  logic          xferN,
  output stageStrobes_t strobes
);
  always_comb begin
    strobes.loadIn  = !chipSelN && !wrOneN && latchEn;
    strobes.loadDac = !wrTwoN && !xferN;
  end

  // R5: a low latch enable blocks every input-stage load
  p_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    !latchEn |-> !strobes.loadIn);
endmodule

// File: rtl/dacfe_datapath.sv
module dacfe_datapath
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobes_t     strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W-1:0] dacCodeInv
);
  localparam logic [DATA_W-1:0] ZERO_CODE = '0;
  localparam int SUM_W = DATA_W + 1;
  localparam logic [SUM_W-1:0] FULL_SUM = SUM_W'((1 << DATA_W) - 1);

  logic [DATA_W-1:0] inReg;
  logic [DATA_W-1:0] inNext;

  // cascaded transparency: the converter stage sees what the input stage takes
  always_comb inNext = strobes.loadIn ? dataIn : inReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg   <= ZERO_CODE;
      dacCode <= ZERO_CODE;
    end else begin
      inReg <= inNext;
      if (strobes.loadDac) dacCode <= inNext;
    end
  end

  always_comb dacCodeInv = ~dacCode;

  p_inhold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadIn |=> $stable(inReg));
  p_dachold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadDac |=> $stable(dacCode));
  p_xfer_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadDac && !strobes.loadIn) |=> (dacCode == $past(inReg)));
  p_flow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadDac && strobes.loadIn) |=> (dacCode == $past(dataIn)));
  p_sum_r6: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, dacCode} + {1'b0, dacCodeInv}) == FULL_SUM);
endmodule

// File: rtl/dbuf_dac_front.sv
module dbuf_dac_front
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              latchEn,
  input  logic              wrOneN,
  input  logic              wrTwoN,
  input  logic              xferN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dacCode,
  output logic [DATA_W-1:0] dacCodeInv
);
  stageStrobes_t strobes;

  dacfe_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .latchEn(latchEn),
    .wrOneN(wrOneN), .wrTwoN(wrTwoN), .xferN(xferN), .strobes(strobes)
  );

  dacfe_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .dacCode(dacCode), .dacCodeInv(dacCodeInv)
  );

  // R1: zero-scale code while reset is held
  always_comb begin
    if (!rstN) p_rst_r1: assert (dacCode == '0);
  end
endmodule

// File: tb/dbuf_dac_front_test.sv
module dbuf_dac_front_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSelN = 1'b1, latchEn = 1'b1, wrOneN = 1'b1, wrTwoN = 1'b1, xferN = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dacCode, dacCodeInv;

  typedef struct {
    logic [7:0] code;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  logic [7:0] mIn = 8'h00;
  logic [7:0] mDac = 8'h00;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dbuf_dac_front uut (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .latchEn(latchEn),
    .wrOneN(wrOneN), .wrTwoN(wrTwoN), .xferN(xferN), .dataIn(dataIn),
    .dacCode(dacCode), .dacCodeInv(dacCodeInv)
  );

  task automatic step(input logic cs, input logic ile, input logic w1,
                      input logic w2, input logic xf, input logic [7:0] d,
                      input string tag);
    expItem_t it;
    logic [7:0] nIn;
    chipSelN = cs; latchEn = ile; wrOneN = w1; wrTwoN = w2; xferN = xf; dataIn = d;
    nIn = (!cs && !w1 && ile) ? d : mIn;
    if (!w2 && !xf) mDac = nIn;
    mIn = nIn;
    @(posedge clk);
    #1;
    it.code = mDac;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compares one expectation per cycle at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        total++;
        if (dacCode !== it.code) begin
          bad++;
          $display("FAIL %s dacCode actual=%h expected=%h", it.tag, dacCode, it.code);
        end
        total++;
        if (dacCodeInv !== ~it.code) begin
          bad++;
          $display("FAIL R6 dacCodeInv actual=%h expected=%h", dacCodeInv, ~it.code);
        end
      end
    end
  end

  initial begin
    #40000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (dacCode !== 8'h00 || dacCodeInv !== 8'hFF) begin
      bad++;
      $display("FAIL R1 in reset actual=%h/%h expected=00/ff", dacCode, dacCodeInv);
    end
    rstN = 1'b1;
    @(posedge clk); #1;
    total++;
    if (dacCode !== 8'h00 || dacCodeInv !== 8'hFF) begin
      bad++;
      $display("FAIL R1 after reset actual=%h/%h expected=00/ff", dacCode, dacCodeInv);
    end
    // double-buffered: write without transfer, then transfer
    step(0, 1, 0, 1, 1, 8'h5A, "R7");
    step(1, 1, 1, 1, 1, 8'hEE, "R7");
    step(1, 1, 1, 0, 0, 8'h00, "R3");
    // transfer path partly closed
    step(0, 1, 0, 0, 1, 8'h11, "R3");
    step(0, 1, 0, 1, 0, 8'h22, "R3");
    // chip select high ignores write; then transfer shows old byte
    step(1, 1, 0, 1, 1, 8'hC3, "R2");
    step(1, 1, 1, 0, 0, 8'h00, "R2");
    // latch enable low freezes input stage, even with transfer open
    step(0, 0, 0, 1, 1, 8'h77, "R5");
    step(0, 0, 0, 0, 0, 8'h66, "R5");
    step(1, 1, 1, 0, 0, 8'h00, "R5");
    // flow-through
    step(0, 1, 0, 0, 0, 8'h81, "R4");
    step(0, 1, 0, 0, 0, 8'h00, "R4");
    step(0, 1, 0, 0, 0, 8'hFF, "R4");
    step(0, 1, 0, 0, 0, 8'h01, "R4");
    // single-buffered: strobe write 1, then bus moves
    step(0, 1, 1, 0, 0, 8'h44, "R8");
    step(0, 1, 0, 0, 0, 8'h3C, "R8");
    step(0, 1, 1, 0, 0, 8'h99, "R8");
    step(0, 1, 1, 0, 0, 8'hA5, "R8");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule